// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller

This block is a bank of general-purpose pins behind a small word-addressed register bus. Software chooses a direction for each pin and, for outputs, whether the pin is push-pull or open-drain. It writes an output latch and reads back a data word that mixes live input levels with latch values. Input levels pass through a two-flop synchroniser. A per-pin edge qualifier then records selected transitions in a pending-event register, and software clears that register by writing ones. Pending events that are also enabled in a mask register are ORed into a single interrupt line.

The `DUAL_CTRL` parameter picks the edge-control scheme. With one bit per pin, a pin either reacts only to falling edges or reacts to both edges. With two bits per pin, the fields are spread over two control words, and each pin can select rising only, falling only or both. Pin n is bit (NPINS-1-n) in every per-pin register, so pin 0 is the most significant bit. The bus carries bits 4:2 of a byte address: word index 0 is direction, 1 open-drain, 2 data, 3 pending events, 4 mask, 5 first control word, 6 second control word.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After a synchronous active-low reset every register reads zero, no pad is driven (pad_oe all 0) and irq is low.
- R2: Pin n corresponds to register bit (31-n) in every per-pin register; pad port index n is pin n.
- R3: A direction bit of 1 makes the pin an output; a push-pull output (open-drain bit 0) drives its latch value with pad_oe high.
- R4: An output with its open-drain bit at 1 drives low (pad_oe 1, pad_o 0) for latch 0 and releases the pad (pad_oe 0) for latch 1.
- R5: A read of word 2 returns the latch bit for output pins and the synchronised pad level for input pins.
- R6: A pad change applied before clock edge k appears in the event register after edge k+2 and not after edge k+1.
- R7: Writing 1 to an event bit clears it and writing 0 leaves it unchanged; an edge qualified in the same cycle as the clearing write leaves the bit set.
- R8: irq is high exactly when some event bit and the same mask bit are both 1.
- R9: With DUAL_CTRL=0, control bit 1 records only falling edges and control bit 0 records both edges.
- R10: With DUAL_CTRL=1, pins 0..15 take their code from word 5 and pins 16..31 from word 6, pin p in bits [2*(15 - p mod 16)+1 : 2*(15 - p mod 16)]; code 2'b10 records falling edges, 2'b01 rising edges, 2'b00 and 2'b11 both edges.
- R11: With DUAL_CTRL=0, word 6 reads zero and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; read data is zero when low |
| bus_addr | input | 3 | Word index (byte address bits 4:2) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pad_i | input | 32 | Pad input levels, index n is pin n |
| pad_o | output | 32 | Pad output values, index n is pin n |
| pad_oe | output | 32 | Pad output enables, index n is pin n |
| irq | output | 1 | Combined interrupt |

## Verification
Both control variants run side by side on the same bus and pad stimulus. Each is swept with several control-word patterns, including all zeros, all ones and mixed values, and every pattern is followed by a rise of every pad and then a fall. The rise shows which pins accept rising edges and the fall shows which accept falling edges, so a code assigned to the wrong pin, word or field shows up as a wrong bit. A read one cycle before the expected latching cycle separates correct synchroniser depth from a path that is one stage too short. Mixed direction, open-drain and latch patterns check the bit reversal against push-pull and open-drain drive and against the mixed data read.

// File: rtl/gpio_edge_pkg.sv
// Shared constants for the edge-interrupt GPIO controller.
// Assumes a bus word index of 3 bits (byte address bits 4:2).
package gpio_edge_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] IDX_DIR = 3'd0;
    localparam logic [ADDR_W-1:0] IDX_ODR = 3'd1;
    localparam logic [ADDR_W-1:0] IDX_DAT = 3'd2;
    localparam logic [ADDR_W-1:0] IDX_EVT = 3'd3;
    localparam logic [ADDR_W-1:0] IDX_MSK = 3'd4;
    localparam logic [ADDR_W-1:0] IDX_CTA = 3'd5;
    localparam logic [ADDR_W-1:0] IDX_CTB = 3'd6;

    // Edge selection code of one pin.
    typedef enum logic [1:0] {
        SEL_BOTH = 2'b00,
        SEL_RISE = 2'b01,
        SEL_FALL = 2'b10,
        SEL_ANY  = 2'b11
    } edge_sel_t;

endpackage

// File: rtl/gpio_edge_sync.sv
// Two-flop synchroniser for a vector of asynchronous pad levels.
// Assumes each bit is independent; no bus coherency is claimed.
module gpio_edge_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Two register stages between the pad and the logic.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_edge_qual.sv
// Per-pin edge qualifier: compares the current and previous synchronised
// level and reports a hit when the transition matches the selected code.
// Assumes lvl_prev is lvl_now delayed by exactly one clock.
module gpio_edge_qual
    import gpio_edge_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      lvl_now,
    input  logic      lvl_prev,
    input  edge_sel_t sel,
    output logic      hit
);
    logic went_up;
    logic went_down;

    // Classify the transition and gate it by the selection code.
    always_comb begin
        went_up   = lvl_now & ~lvl_prev;
        went_down = ~lvl_now & lvl_prev;
        hit       = (went_up & (sel != SEL_FALL)) | (went_down & (sel != SEL_RISE));
    end

    // R9 / R10: a falling-only pin hits only when the level is now low.
    p_fall_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_FALL && hit) |-> !lvl_now);

    // R10: a rising-only pin hits only when the level is now high.
    p_rise_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_RISE && hit) |-> lvl_now);
endmodule

// File: rtl/gpio_edge_ctrl.sv
// Edge-interrupt GPIO controller: register file, pad drive, synchronised
// input path, per-pin edge qualification, pending events and the combined
// interrupt. Register bit b serves pin NPINS-1-b. DUAL_CTRL selects one
// control bit per pin (falling only / both) or two bits per pin over two
// control words. Assumes NPINS is even and equals the bus data width.
module gpio_edge_ctrl
    import gpio_edge_pkg::*;
#(
    parameter int NPINS     = 32,
    parameter bit DUAL_CTRL = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pad_i,
    output logic [NPINS-1:0]  pad_o,
    output logic [NPINS-1:0]  pad_oe,
    output logic              irq
);
    localparam int HALF = NPINS / 2;

    logic [NPINS-1:0] dir_q, odr_q, dat_q, evt_q, msk_q, cta_q, ctb_q;
    logic [NPINS-1:0] pad_rb;      // pads in register-bit order
    logic [NPINS-1:0] lvl_now;
    logic [NPINS-1:0] lvl_prev_q;
    logic [NPINS-1:0] hit_w;
    logic [NPINS-1:0] drv_en;
    logic [NPINS-1:0] drv_val;
    logic [NPINS-1:0] evt_clr;
    edge_sel_t        sel_w [NPINS];

    // Write decode for the registers shared by both variants.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
            odr_q <= '0;
            dat_q <= '0;
            msk_q <= '0;
            cta_q <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                IDX_DIR: dir_q <= bus_wdata;
                IDX_ODR: odr_q <= bus_wdata;
                IDX_DAT: dat_q <= bus_wdata;
                IDX_MSK: msk_q <= bus_wdata;
                IDX_CTA: cta_q <= bus_wdata;
                default: ;
            endcase
        end
    end

    generate
        if (DUAL_CTRL) begin : g_ctb
            // Second control word exists only in the two-bit variant.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    ctb_q <= '0;
                else if (bus_wr && bus_addr == IDX_CTB)
                    ctb_q <= bus_wdata;
            end
        end else begin : g_no_ctb
            assign ctb_q = '0;
        end
    endgenerate

    // Pending events: write-one clears, a new hit wins over a clear.
    always_comb evt_clr = (bus_wr && bus_addr == IDX_EVT) ? bus_wdata : '0;

    always_ff @(posedge clk) begin
        if (!rst_n)
            evt_q <= '0;
        else
            evt_q <= (evt_q & ~evt_clr) | hit_w;
    end

    // Previous synchronised level, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lvl_prev_q <= '0;
        else
            lvl_prev_q <= lvl_now;
    end

    gpio_edge_sync #(.W(NPINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_rb),
        .q     (lvl_now)
    );

    genvar b;
    generate
        for (b = 0; b < NPINS; b++) begin : g_pin
            localparam int FLD = b % HALF;

            // Reverse pin numbering onto register bits.
            assign pad_rb[b]             = pad_i[NPINS-1-b];
            assign pad_o[NPINS-1-b]      = drv_val[b];
            assign pad_oe[NPINS-1-b]     = drv_en[b];

            if (DUAL_CTRL) begin : g_two
                if (b >= HALF) begin : g_lo_pins
                    assign sel_w[b] = edge_sel_t'(cta_q[2*FLD+1:2*FLD]);
                end else begin : g_hi_pins
                    assign sel_w[b] = edge_sel_t'(ctb_q[2*FLD+1:2*FLD]);
                end
            end else begin : g_one
                assign sel_w[b] = cta_q[b] ? SEL_FALL : SEL_BOTH;
            end

            gpio_edge_qual u_qual (
                .clk      (clk),
                .rst_n    (rst_n),
                .lvl_now  (lvl_now[b]),
                .lvl_prev (lvl_prev_q[b]),
                .sel      (sel_w[b]),
                .hit      (hit_w[b])
            );
        end
    endgenerate

    // Pad drive: open-drain outputs release on a latched one.
    always_comb begin
        drv_en  = dir_q & ~(odr_q & dat_q);
        drv_val = dir_q & dat_q & ~odr_q;
    end

    // Combined interrupt from enabled pending events.
    always_comb irq = |(evt_q & msk_q);

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                IDX_DIR: bus_rdata = dir_q;
                IDX_ODR: bus_rdata = odr_q;
                IDX_DAT: bus_rdata = (dat_q & dir_q) | (lvl_now & ~dir_q);
                IDX_EVT: bus_rdata = evt_q;
                IDX_MSK: bus_rdata = msk_q;
                IDX_CTA: bus_rdata = cta_q;
                IDX_CTB: bus_rdata = ctb_q;
                default: bus_rdata = '0;
            endcase
        end
    end

    // R7: bits written with one and not re-hit are clear next cycle.
    p_evt_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == IDX_EVT) |=>
            ((evt_q & $past(bus_wdata) & ~$past(hit_w)) == '0));

    // R6: every qualified hit is pending in the following cycle.
    p_evt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_w != '0) |=> ((evt_q & $past(hit_w)) == $past(hit_w)));

    // R6: no event bit rises without a qualified hit.
    p_evt_nospur_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_w == '0) |=> ((evt_q & ~$past(evt_q)) == '0));
endmodule

// File: tb/test_gpio_edge_ctrl.sv
module test_gpio_edge_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [2:0]    bus_addr = '0;
    logic [NP-1:0] bus_wdata = '0;
    logic [NP-1:0] pad_i = '0;
    logic [NP-1:0] rdata_s, rdata_d, pado_s, pado_d, padoe_s, padoe_d;
    logic          irq_s, irq_d;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_edge_ctrl #(.NPINS(NP), .DUAL_CTRL(1'b0)) i_gpio_edge_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_s),
        .pad_i(pad_i), .pad_o(pado_s), .pad_oe(padoe_s), .irq(irq_s));

    gpio_edge_ctrl #(.NPINS(NP), .DUAL_CTRL(1'b1)) i_gpio_edge_ctrl_dual (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_d),
        .pad_i(pad_i), .pad_o(pado_d), .pad_oe(padoe_d), .irq(irq_d));

    function automatic logic [NP-1:0] rev(input logic [NP-1:0] v);
        logic [NP-1:0] r;
        for (int i = 0; i < NP; i++) r[i] = v[NP-1-i];
        return r;
    endfunction

    // Expected register-order event word for the two-bit scheme (R10).
    function automatic logic [NP-1:0] dual_exp(input logic [NP-1:0] c1,
                                               input logic [NP-1:0] c2,
                                               input bit rising);
        logic [NP-1:0] e = '0;
        for (int p = 0; p < NP; p++) begin
            int sh = 2 * (15 - (p % 16));
            logic [1:0] c = (p < 16) ? c1[sh +: 2] : c2[sh +: 2];
            e[31-p] = rising ? (c != 2'b10) : (c != 2'b01);
        end
        return e;
    endfunction

    task automatic chk(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [NP-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = idx; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] idx, output logic [NP-1:0] s, output logic [NP-1:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = idx;
        #1 s = rdata_s; d = rdata_d;
        bus_rd = 1'b0;
    endtask

    task automatic edge_pattern(input logic [NP-1:0] c1, input logic [NP-1:0] c2);
        logic [NP-1:0] s, d;
        wr(3'd5, c1);
        wr(3'd6, c2);
        wr(3'd3, '1);
        rd(3'd6, s, d);
        chk("R11 second control word ignored", s, '0);
        chk("R10 second control word stored", d, c2);
        @(negedge clk) pad_i = '1;
        @(posedge clk); @(posedge clk);
        rd(3'd3, s, d);
        chk("R6 no event one cycle early (single)", s, '0);
        chk("R6 no event one cycle early (dual)", d, '0);
        @(posedge clk);
        rd(3'd3, s, d);
        chk("R9 rising edges, single mode", s, ~c1);
        chk("R10 rising edges, dual mode", d, dual_exp(c1, c2, 1'b1));
        wr(3'd3, '1);
        @(negedge clk) pad_i = '0;
        repeat (3) @(posedge clk);
        rd(3'd3, s, d);
        chk("R9 falling edges, single mode", s, '1);
        chk("R10 falling edges, dual mode", d, dual_exp(c1, c2, 1'b0));
        wr(3'd3, '1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [NP-1:0] s, d;
        logic [NP-1:0] dirv, odrv, datv, padv;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        for (int i = 0; i < 7; i++) begin
            rd(3'(i), s, d);
            chk("R1 register clear (single)", s, '0);
            chk("R1 register clear (dual)", d, '0);
        end
        chk("R1 pads released", padoe_s | padoe_d, '0);
        chk("R1 irq low", {31'b0, irq_s | irq_d}, '0);

        // R2: pin 0 is register MSB
        wr(3'd0, 32'h8000_0000);
        wr(3'd2, 32'h8000_0000);
        @(negedge clk);
        chk("R2 pin0 enable from MSB", padoe_s, 32'h1);
        chk("R2 pin0 value from MSB", pado_s, 32'h1);

        // R4: open drain on pin 3 (bit 28)
        wr(3'd0, 32'h1000_0000);
        wr(3'd1, 32'h1000_0000);
        wr(3'd2, 32'h0000_0000);
        @(negedge clk);
        chk("R4 open-drain latch 0 drives", padoe_s & 32'h8, 32'h8);
        chk("R4 open-drain latch 0 low", pado_s & 32'h8, 32'h0);
        wr(3'd2, 32'h1000_0000);
        @(negedge clk);
        chk("R4 open-drain latch 1 released", padoe_s & 32'h8, 32'h0);

        // R3 R5: mixed pattern
        dirv = 32'hF0F0_F0F0; odrv = 32'h3333_0000;
        datv = 32'h5A5A_A5A5; padv = 32'h1234_5678;
        wr(3'd0, dirv); wr(3'd1, odrv); wr(3'd2, datv);
        @(negedge clk) pad_i = padv;
        repeat (3) @(posedge clk);
        chk("R3 output enables", padoe_s, rev(dirv & ~(odrv & datv)));
        chk("R3 output values", pado_s, rev(dirv & datv & ~odrv));
        rd(3'd2, s, d);
        chk("R5 data read mix", s, (datv & dirv) | (rev(padv) & ~dirv));
        @(negedge clk) pad_i = '0;
        repeat (3) @(posedge clk);
        wr(3'd0, '0); wr(3'd1, '0); wr(3'd2, '0);
        wr(3'd3, '1);

        // R9 R10: edge sweeps
        edge_pattern(32'h0000_0000, 32'h0000_0000);
        edge_pattern(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        edge_pattern(32'hAAAA_AAAA, 32'h5555_5555);
        edge_pattern(32'h9E37_79B9, 32'h1B87_3C2D);
        edge_pattern(32'h1234_5678, 32'hA5C3_0F96);

        // R7 R8: clears and interrupt
        wr(3'd5, '0); wr(3'd6, '0);
        @(negedge clk) pad_i = '1;
        repeat (3) @(posedge clk);
        rd(3'd3, s, d);
        chk("R7 all pending", s, '1);
        @(negedge clk);
        chk("R8 masked irq low", {31'b0, irq_s}, '0);
        wr(3'd4, 32'h0400_0000);
        @(negedge clk);
        chk("R8 irq on pin5", {31'b0, irq_s}, 32'h1);
        wr(3'd3, 32'h0000_0000);
        rd(3'd3, s, d);
        chk("R7 writing zero keeps events", s, '1);
        wr(3'd3, 32'h0400_0000);
        rd(3'd3, s, d);
        chk("R7 one clears only its bit", s, 32'hFBFF_FFFF);
        @(negedge clk);
        chk("R8 irq drops after clear", {31'b0, irq_s}, '0);
        wr(3'd3, 32'h0000_FFFF);
        rd(3'd3, s, d);
        chk("R7 low half clear", s, 32'hFBFF_0000);
        wr(3'd3, '1);
        wr(3'd4, '0);

        // R7: edge in the same cycle as clear wins
        @(negedge clk) pad_i = '0;
        @(posedge clk);
        @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'd3; bus_wdata = '1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
        rd(3'd3, s, d);
        chk("R7 new edge beats clear (single)", s, '1);
        chk("R7 new edge beats clear (dual)", d, '1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule